// File: doc/BRIEF.md
# Oversampled serial receiver with per-character line status

The block takes an asynchronous serial line, sampled on a 16x tick, and assembles frames of one start bit, eight data bits sent least significant bit first, and one stop bit. Each character is stored with three error tags: parity, framing and break. The parity tag is always stored as zero because this frame carries no parity bit. Characters go into a receive queue that a CPU drains with a read strobe. A CPU status read returns framing-error and break flags, plus a summary flag that reports errored characters still held in the queue.

In queued mode the queue holds up to 16 characters. The framing and break flags describe the character at the head of the queue. In single mode there is one holding register that always keeps the newest character, and the flags stay set until the CPU reads the status. The receiver recovers after a bad stop bit by taking that low level as the next start bit. A long spacing condition becomes one zero character, and the receiver waits for the line to be high for half a bit before it will see a new start bit.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, data_ready_o, frame_err_o, break_o and fifo_err_o are all 0.
- R2: A low level seen on a tick starts a frame only if the line is still low on the 8th tick counted from that first low tick. If it is high there, the frame is abandoned and no character is produced.
- R3: Data bits are sampled 16 ticks apart and arrive least significant bit first. A frame with a high stop bit is delivered at rx_data_o with data_ready_o set, and carries no error flag.
- R4: A character whose stop-bit sample is 0, and whose data bits are not all zero, is tagged with a framing error.
- R5: After a framing error, the low stop level is checked once more on the next tick as a start bit. If it is still low, the following eight bit times are received as a new character.
- R6: When the start, all eight data samples and the stop sample are all low, exactly one 0x00 character is stored, tagged as a break and not as a framing error.
- R7: After a break, no new frame can start until the line has been high on 8 consecutive ticks. A low level before that point restarts the count.
- R8: In queued mode (fifo_mode_i=1), up to 16 characters are kept in arrival order, and each rbr_rd_i pulse removes the head. A character that arrives while 16 are held is dropped.
- R9: In queued mode, frame_err_o and break_o show the tags of the current head character. They are cleared by an lsr_rd_i pulse and reloaded each time a new character becomes the head.
- R10: In single mode (fifo_mode_i=0), only the newest character is held. frame_err_o and break_o accumulate across characters until an lsr_rd_i pulse clears them.
- R11: fifo_err_o is 0 in single mode. In queued mode it is set when an errored character is stored. An lsr_rd_i pulse clears it only when no errored character remains in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial data line, idle high |
| tick16_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| fifo_mode_i | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| lsr_rd_i | input | 1 | Line-status read strobe |
| rbr_rd_i | input | 1 | Receive-data read strobe, pops the head |
| rx_data_o | output | 8 | Head character |
| data_ready_o | output | 1 | At least one character held |
| frame_err_o | output | 1 | Framing-error flag |
| break_o | output | 1 | Break flag |
| fifo_err_o | output | 1 | Errored character held in queue |

## Verification
On every cycle, the assertions check several things. A mid-bit high level during start validation returns the receiver to idle. A break entry always carries zero data and never a framing tag. The queue occupancy never goes past its depth. A status read with no new head clears the framing and break flags. The summary flag drops after a read once no errored entry remains. Only the bench scenarios can show the rest: the bit-level timing of resynchronisation after a bad stop bit, that a held-low line gives exactly one zero character, that a short high pulse does not re-arm the receiver after a break, the order of a full queue and the dropping of a 17th character, and the difference between head-tied flags and accumulating flags across the two modes.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic parity;
    logic frame;
    logic brk;
  } rx_tag_t;

  typedef struct packed {
    rx_tag_t           tag;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rxd_i,
  input  logic      tick_i,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned BW   = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] TOP  = BW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q, hcnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shift_q;
  logic              all_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hcnt_q    <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      all_low_q <= 1'b0;
      push_o    <= 1'b0;
      entry_o   <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rxd_i) begin
            state_q <= ST_START;
            cnt_q   <= CW'(1);
          end
          ST_START: begin
            if (cnt_q == MID) begin
              cnt_q     <= '0;
              bit_q     <= '0;
              all_low_q <= 1'b1;
              state_q   <= rxd_i ? ST_IDLE : ST_DATA;  // glitch rejection
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q     <= '0;
              shift_q   <= {rxd_i, shift_q[DATA_W-1:1]};
              all_low_q <= all_low_q & ~rxd_i;
              if (bit_q == TOP) state_q <= ST_STOP;
              else bit_q <= bit_q + BW'(1);
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_STOP: begin
            if (cnt_q == LAST) begin
              push_o       <= 1'b1;
              entry_o.data <= shift_q;
              entry_o.tag  <= '0;
              if (rxd_i) begin
                cnt_q   <= '0;
                state_q <= ST_IDLE;
              end else if (all_low_q) begin
                entry_o.tag.brk <= 1'b1;
                hcnt_q          <= '0;
                cnt_q           <= '0;
                state_q         <= ST_BRK;
              end else begin
                // bad stop bit: treat it as the next start bit, recheck on next tick
                entry_o.tag.frame <= 1'b1;
                cnt_q             <= MID;
                state_q           <= ST_START;
              end
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_BRK: begin
            if (!rxd_i)            hcnt_q <= '0;
            else if (hcnt_q == MID) begin
              hcnt_q  <= '0;
              state_q <= ST_IDLE;
            end else               hcnt_q <= hcnt_q + CW'(1);
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  a_r2_glitch_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_START && cnt_q == MID && rxd_i) |=> state_q == ST_IDLE);
  a_r3_push_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_o) |-> $past(state_q) == ST_STOP);
  a_r6_break_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && entry_o.tag.brk) |-> (entry_o.data == '0 && !entry_o.tag.frame));
  a_r7_break_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRK && tick_i && !rxd_i) |=> state_q == ST_BRK);
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       single_i,
  input  logic                       push_i,
  input  rx_entry_t                  entry_i,
  input  logic                       pop_i,
  output rx_entry_t                  head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       load_o,
  output rx_tag_t                    load_tag_o,
  output logic                       drain_o,
  output logic                       errors_held_o
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CNTW = $clog2(DEPTH+1);

  rx_entry_t         mem_q [DEPTH];
  logic [AW-1:0]     rd_q, wr_q;
  logic [CNTW-1:0]   cnt_q;
  logic              do_push, do_pop;
  logic [DEPTH-1:0]  held;

  assign do_pop  = pop_i && cnt_q != '0 && !(single_i && push_i);
  assign do_push = push_i && (single_i || cnt_q != CNTW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[single_i ? '0 : wr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (single_i && do_push) begin
      rd_q  <= '0;
      wr_q  <= AW'(1);
      cnt_q <= CNTW'(1);
    end else begin
      if (do_push) wr_q <= wr_q + AW'(1);
      if (do_pop)  rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  // head change events for the status flags
  always_comb begin
    load_o     = 1'b0;
    load_tag_o = '0;
    drain_o    = 1'b0;
    if (single_i && do_push) begin
      load_o     = 1'b1;
      load_tag_o = entry_i.tag;
    end else if (do_pop && cnt_q > CNTW'(1)) begin
      load_o     = 1'b1;
      load_tag_o = mem_q[rd_q + AW'(1)].tag;
    end else if (do_push && (cnt_q == '0 || do_pop)) begin
      load_o     = 1'b1;
      load_tag_o = entry_i.tag;
    end else if (do_pop) begin
      drain_o = 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_held
    logic [AW-1:0] off;
    assign off     = AW'(g) - rd_q;
    assign held[g] = ({1'b0, off} < cnt_q) && (mem_q[g].tag != '0);
  end

  assign errors_held_o = |held;
  assign head_o        = mem_q[rd_q];
  assign count_o       = cnt_q;

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNTW'(DEPTH));
  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_i && cnt_q == CNTW'(DEPTH) && push_i && !pop_i) |=> cnt_q == CNTW'(DEPTH));
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
  import serial_rx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fifo_mode_i,
  input  logic    lsr_rd_i,
  input  logic    load_i,
  input  rx_tag_t load_tag_i,
  input  logic    drain_i,
  input  logic    err_push_i,
  input  logic    errors_held_i,
  output logic    frame_err_o,
  output logic    break_o,
  output logic    fifo_err_o
);
  logic fe_q, bi_q, sum_q;
  logic fe_base, bi_base;

  assign fe_base = lsr_rd_i ? 1'b0 : fe_q;
  assign bi_base = lsr_rd_i ? 1'b0 : bi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
      sum_q <= 1'b0;
    end else begin
      if (load_i) begin
        // queued mode: flags follow the head; single mode: accumulate
        fe_q <= (fifo_mode_i ? 1'b0 : fe_base) | load_tag_i.frame;
        bi_q <= (fifo_mode_i ? 1'b0 : bi_base) | load_tag_i.brk;
      end else if (drain_i && fifo_mode_i) begin
        fe_q <= 1'b0;
        bi_q <= 1'b0;
      end else begin
        fe_q <= fe_base;
        bi_q <= bi_base;
      end
      if (!fifo_mode_i)    sum_q <= 1'b0;
      else if (err_push_i) sum_q <= 1'b1;
      else if (lsr_rd_i)   sum_q <= errors_held_i;
    end
  end

  assign frame_err_o = fe_q;
  assign break_o     = bi_q;
  assign fifo_err_o  = fifo_mode_i & sum_q;

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !load_i) |=> (!frame_err_o && !break_o));
  a_r11_sum_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !err_push_i && !errors_held_i) |=> !fifo_err_o);
  a_r11_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && err_push_i) |=> (sum_q || !fifo_mode_i));
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              fifo_mode_i,
  input  logic              lsr_rd_i,
  input  logic              rbr_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              data_ready_o,
  output logic              frame_err_o,
  output logic              break_o,
  output logic              fifo_err_o
);
  localparam int unsigned CNTW = $clog2(DEPTH+1);

  logic            push, load, drain, held;
  rx_entry_t       entry, head;
  rx_tag_t         load_tag;
  logic [CNTW-1:0] count;

  serial_rx_sampler #(.OVS(OVS)) u_sampler (
    .clk_i, .rst_ni, .rxd_i, .tick_i(tick16_i),
    .push_o(push), .entry_o(entry)
  );

  serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .single_i(!fifo_mode_i),
    .push_i(push), .entry_i(entry), .pop_i(rbr_rd_i),
    .head_o(head), .count_o(count), .load_o(load), .load_tag_o(load_tag),
    .drain_o(drain), .errors_held_o(held)
  );

  serial_rx_flags u_flags (
    .clk_i, .rst_ni, .fifo_mode_i, .lsr_rd_i,
    .load_i(load), .load_tag_i(load_tag), .drain_i(drain),
    .err_push_i(push && entry.tag != '0 && count != CNTW'(DEPTH)),
    .errors_held_i(held),
    .frame_err_o, .break_o, .fifo_err_o
  );

  assign rx_data_o    = head.data;
  assign data_ready_o = count != '0;

  a_r10_single_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i |=> (count <= CNTW'(1) || $past(fifo_mode_i)));
endmodule

// File: tb/serial_rx_status_bench.sv
module serial_rx_status_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rxd = 1'b1, tick = 1'b0, fmode = 1'b1, lsr_rd = 1'b0, rbr_rd = 1'b0;
  logic [7:0] rdata;
  logic       rdy, fe, bi, ferr;
  int         n_chk = 0, n_bad = 0;

  typedef struct { logic [7:0] d; logic fe; logic bi; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  serial_rx_status u_serial_rx_status (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick16_i(tick),
    .fifo_mode_i(fmode), .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd),
    .rx_data_o(rdata), .data_ready_o(rdy), .frame_err_o(fe),
    .break_o(bi), .fifo_err_o(ferr)
  );

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(logic b, int ticks);
    @(negedge clk);
    rxd = b;
    repeat (ticks * 4 - 1) @(negedge clk);
  endtask

  task automatic data_stop(logic [7:0] d, logic stp);
    for (int i = 0; i < 8; i++) hold(d[i], 16);
    hold(stp, 16);
  endtask

  task automatic frame(logic [7:0] d, logic stp);
    hold(1'b0, 16);
    data_stop(d, stp);
  endtask

  task automatic expect_item(logic [7:0] d, logic f, logic b);
    exp_t e;
    e.d = d; e.fe = f; e.bi = b;
    exp_q.push_back(e);
  endtask

  task automatic pulse_lsr();
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare head against the oldest expected item, then pop it
  task automatic take(string req);
    exp_t e;
    @(negedge clk);
    chk({req, " ready"}, rdy, 1);
    if (exp_q.size() == 0) begin
      chk({req, " queue"}, 0, 1);
    end else begin
      e = exp_q.pop_front();
      chk({req, " data"}, rdata, e.d);
      chk({req, " fe"}, fe, e.fe);
      chk({req, " bi"}, bi, e.bi);
    end
    rbr_rd = 1'b1;
    @(negedge clk); rbr_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ready", rdy, 0); chk("R1 fe", fe, 0); chk("R1 bi", bi, 0); chk("R1 ferr", ferr, 0);
    rst_n = 1'b1;
    hold(1'b1, 32);

    // R3 plain frames, LSB first
    frame(8'hA5, 1'b1); expect_item(8'hA5, 0, 0);
    frame(8'h3C, 1'b1); expect_item(8'h3C, 0, 0);
    hold(1'b1, 8);
    take("R3 a5"); take("R3 3c");
    chk("R3 empty", rdy, 0);

    // R2 short low pulse is rejected
    hold(1'b0, 5); hold(1'b1, 40);
    chk("R2 glitch ignored", rdy, 0);

    // R4 framing error then R5 resync onto 0xA3
    frame(8'h11, 1'b1); expect_item(8'h11, 0, 0);
    hold(1'b1, 4);
    frame(8'h55, 1'b0); expect_item(8'h55, 1, 0);
    data_stop(8'hA3, 1'b1); expect_item(8'hA3, 0, 0);
    hold(1'b1, 8);
    // R6 break: long low gives one zero character
    hold(1'b0, 16 * 12); expect_item(8'h00, 0, 1);
    // R7 short high does not re-arm; later low must not start a frame
    hold(1'b1, 3); hold(1'b0, 32); hold(1'b1, 32);
    frame(8'h5A, 1'b1); expect_item(8'h5A, 0, 0);
    hold(1'b1, 8);

    // R11 summary and R9 head-tied flags
    chk("R11 ferr set", ferr, 1);
    chk("R9 head 11 fe", fe, 0);
    pulse_lsr();
    chk("R11 ferr kept while errors held", ferr, 1);
    take("R3 11");
    chk("R4 head 55 fe", fe, 1);
    pulse_lsr();
    chk("R9 fe cleared by read", fe, 0);
    chk("R11 ferr still set", ferr, 1);
    void'(exp_q.pop_front()); // 0x55 fe already read away
    @(negedge clk); rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0; @(negedge clk);
    take("R5 resync a3");
    take("R6 break char");
    take("R7 rearm 5a");
    chk("R6 only one break char", rdy, 0);
    pulse_lsr();
    chk("R11 ferr released", ferr, 0);

    // R8 fill 17, 17th dropped
    for (int i = 0; i < 17; i++) begin
      frame(8'(i + 8'h40), 1'b1);
      if (i < 16) expect_item(8'(i + 8'h40), 0, 0);
      hold(1'b1, 2);
    end
    for (int i = 0; i < 16; i++) take("R8 order");
    chk("R8 overflow dropped", rdy, 0);

    // R10 single mode
    fmode = 1'b0;
    frame(8'h12, 1'b1); hold(1'b1, 4);
    frame(8'h34, 1'b1); hold(1'b1, 4);
    chk("R10 newest held", rdata, 8'h34);
    @(negedge clk); rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0; @(negedge clk);
    chk("R10 single depth", rdy, 0);
    frame(8'h55, 1'b0); data_stop(8'hA3, 1'b1); hold(1'b1, 8);
    chk("R10 data", rdata, 8'hA3);
    chk("R10 fe sticky", fe, 1);
    chk("R11 ferr off in single", ferr, 0);
    pulse_lsr();
    chk("R10 fe cleared", fe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule